// File: doc/BRIEF.md
# Encoded Refresh Interval Timer

This block schedules periodic refresh for a DRAM controller. Software or boot logic hands it a 5-bit code that names a refresh period class and a memory clock frequency class. The block turns that code into a number of memory-clock cycles and counts down from it. Each time the count runs out, the block records one owed refresh and asks the command scheduler to issue it. The interval is set only in memory clocks. No core clock ratio enters the count, and one setting serves every module on the channel.

The scheduler answers each request with a one-cycle acknowledge. The interval counter never waits for that answer, so refreshes stay evenly spaced even when the scheduler is busy. Owed refreshes pile up in a saturating counter. An urgency flag tells the scheduler when it has fallen more than one refresh behind.

Top module: `ref_interval_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, the stored code is 01011, `interval_cycles` reads 1560, `pend_count` is 0, and `ref_req` and `ref_urgent` are low.
- R2: Code bits 4:3 pick the period: 00 = 15.6 us, 01 = 7.8 us, 10 = 3.9 us, 11 = 1.95 us. Bits 2:0 pick the clock: 000 = 100, 001 = 133, 010 = 166, 011 = 200, 100 = 120, 101 = 140, 110 = 150, 111 = 180 MHz. The interval equals period times frequency, rounded to the nearest whole cycle with halves rounded up. For example, 1.95 us at 166 MHz gives 324 and 1.95 us at 150 MHz gives 293. `interval_cycles` shows the interval of the stored code from the cycle after a load.
- R3: Codes 00000 and 01011 both give an interval of 1560 cycles.
- R4: A code is stored only when `cfg_load` is high. The stored code is held until the next load. A load restarts the countdown, and no expiry is counted in the load cycle. The first expiry after a load in cycle L takes effect at edge L+N, where N is the new interval. After reset release it takes effect at the 1560th edge.
- R5: The countdown runs freely. Later expiries follow every N cycles whether or not they are acknowledged.
- R6: Each expiry raises `pend_count` by one. The count saturates at 8.
- R7: `ref_ack` lowers `pend_count` by one when it is non-zero. An acknowledge at zero is ignored. An expiry and an acknowledge in the same cycle leave the count unchanged.
- R8: `ref_req` is high exactly when `pend_count` is non-zero. `ref_urgent` is high exactly when `pend_count` is 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_code | input | 5 | Refresh code: period class in bits 4:3, frequency class in bits 2:0 |
| cfg_load | input | 1 | Stores `cfg_code` and restarts the countdown |
| ref_ack | input | 1 | The scheduler has issued one refresh |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Two or more refreshes are owed |
| pend_count | output | 4 | Number of owed refreshes, from 0 to 8 |
| interval_cycles | output | 12 | Interval of the stored code in memory clocks |

## Verification
The decoder is driven through all 32 codes, so every period and frequency pairing is read back. This shows that the two code fields are not swapped and that non-integer products round correctly. Back-to-back loads of the two aliasing codes confirm that they give the same count. Timing runs use the reset default and the shortest interval. Sampling one cycle before and at the expected edge catches off-by-one reloads. Leaving requests unacknowledged, acknowledging at zero, and landing an acknowledge on an expiry edge separate the saturation, the ignore case and the hold case of the pending counter.

// File: rtl/ref_timer_pkg.sv
`timescale 1ns/1ps
package ref_timer_pkg;

    localparam int CODE_W   = 5;
    localparam int CNT_W    = 12;
    localparam int PEND_MAX = 8;
    localparam int PEND_W   = $clog2(PEND_MAX + 1);
    localparam int NCODES   = 1 << CODE_W;

    typedef enum logic [1:0] {
        PER_15U6 = 2'b00,
        PER_7U8  = 2'b01,
        PER_3U9  = 2'b10,
        PER_1U95 = 2'b11
    } per_cls_e;

    typedef enum logic [2:0] {
        F_100 = 3'b000,
        F_133 = 3'b001,
        F_166 = 3'b010,
        F_200 = 3'b011,
        F_120 = 3'b100,
        F_140 = 3'b101,
        F_150 = 3'b110,
        F_180 = 3'b111
    } frq_cls_e;

    typedef struct packed {
        per_cls_e per;
        frq_cls_e frq;
    } ref_code_t;

    localparam ref_code_t RESET_CODE = '{per: PER_7U8, frq: F_200};

    // period in hundredths of a microsecond
    function automatic int unsigned per_centi_us(per_cls_e p);
        case (p)
            PER_15U6: return 1560;
            PER_7U8:  return 780;
            PER_3U9:  return 390;
            default:  return 195;
        endcase
    endfunction

    function automatic int unsigned frq_mhz(frq_cls_e f);
        case (f)
            F_100:   return 100;
            F_133:   return 133;
            F_166:   return 166;
            F_200:   return 200;
            F_120:   return 120;
            F_140:   return 140;
            F_150:   return 150;
            default: return 180;
        endcase
    endfunction

    // cycles = period * frequency, nearest integer, halves upward
    function automatic logic [CNT_W-1:0] interval_of(ref_code_t c);
        int unsigned prod;
        prod = per_centi_us(c.per) * frq_mhz(c.frq);
        return CNT_W'((prod + 32'd50) / 32'd100);
    endfunction

    localparam logic [CNT_W-1:0] RESET_CYCLES = interval_of(RESET_CODE);

endpackage

// File: rtl/ref_code_decode.sv
`timescale 1ns/1ps
module ref_code_decode
    import ref_timer_pkg::*;
(
    input  ref_code_t        code,
    output logic [CNT_W-1:0] cycles
);

    logic [CNT_W-1:0] rom [NCODES];

    for (genvar i = 0; i < NCODES; i++) begin : g_rom
        assign rom[i] = interval_of(ref_code_t'(CODE_W'(i)));
    end

    assign cycles = rom[code];

endmodule

// File: rtl/ref_interval_cnt.sv
`timescale 1ns/1ps
module ref_interval_cnt
    import ref_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cycles,
    input  logic [CNT_W-1:0] run_cycles,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == '0);
    assign tick   = at_end && !load;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RESET_CYCLES - 1'b1;
        end else if (load) begin
            cnt_q <= load_cycles - 1'b1;
        end else if (at_end) begin
            cnt_q <= run_cycles - 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/ref_pend_track.sv
`timescale 1ns/1ps
module ref_pend_track
    import ref_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              ack,
    output logic [PEND_W-1:0] pend,
    output logic              req,
    output logic              urgent
);

    localparam logic [PEND_W-1:0] TOP = PEND_W'(PEND_MAX);

    logic [PEND_W-1:0] pend_q;
    logic              take;

    assign take = ack && (pend_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (tick && !take) begin
            if (pend_q != TOP) begin
                pend_q <= pend_q + 1'b1;
            end
        end else if (take && !tick) begin
            pend_q <= pend_q - 1'b1;
        end
    end

    assign pend   = pend_q;
    assign req    = (pend_q != '0);
    assign urgent = (pend_q > PEND_W'(1));

endmodule

// File: rtl/ref_interval_timer.sv
`timescale 1ns/1ps
module ref_interval_timer
    import ref_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              cfg_load,
    input  logic              ref_ack,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic [PEND_W-1:0] pend_count,
    output logic [CNT_W-1:0]  interval_cycles
);

    ref_code_t        code_q;
    logic [CNT_W-1:0] new_cycles;
    logic [CNT_W-1:0] cur_cycles;
    logic             tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RESET_CODE;
        end else if (cfg_load) begin
            code_q <= ref_code_t'(cfg_code);
        end
    end

    ref_code_decode u_dec_new (
        .code   (ref_code_t'(cfg_code)),
        .cycles (new_cycles)
    );

    ref_code_decode u_dec_cur (
        .code   (code_q),
        .cycles (cur_cycles)
    );

    ref_interval_cnt u_cnt (
        .clk         (clk),
        .rst         (rst),
        .load        (cfg_load),
        .load_cycles (new_cycles),
        .run_cycles  (cur_cycles),
        .tick        (tick)
    );

    ref_pend_track u_pend (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .ack    (ref_ack),
        .pend   (pend_count),
        .req    (ref_req),
        .urgent (ref_urgent)
    );

    assign interval_cycles = cur_cycles;

endmodule

// File: rtl/ref_interval_timer_chk.sv
`timescale 1ns/1ps
module ref_interval_timer_chk
    import ref_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic              ref_ack,
    input logic              ref_req,
    input logic              ref_urgent,
    input logic [PEND_W-1:0] pend_count,
    input logic [CNT_W-1:0]  interval_cycles
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pend_count == '0 && !ref_req && interval_cycles == RESET_CYCLES));

    assert_load_no_expiry_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && !ref_ack) |=> (pend_count == $past(pend_count)));

    assert_pend_bound_R6: assert property (@(posedge clk) disable iff (rst)
        pend_count <= PEND_W'(PEND_MAX));

    assert_ack_no_growth_R7: assert property (@(posedge clk) disable iff (rst)
        (ref_ack && pend_count != '0) |=> (pend_count <= $past(pend_count)));

    assert_urgent_has_req_R8: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> ref_req);

    assert_req_rise_one_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_req) |-> (pend_count == PEND_W'(1)));

endmodule

bind ref_interval_timer ref_interval_timer_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_load        (cfg_load),
    .ref_ack         (ref_ack),
    .ref_req         (ref_req),
    .ref_urgent      (ref_urgent),
    .pend_count      (pend_count),
    .interval_cycles (interval_cycles)
);

// File: tb/ref_interval_timer_test.sv
`timescale 1ns/1ps
module ref_interval_timer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  cfg_code;
    logic        cfg_load;
    logic        ref_ack;
    logic        ref_req;
    logic        ref_urgent;
    logic [3:0]  pend_count;
    logic [11:0] interval_cycles;

    int tests = 0;
    int fails = 0;

    // expected intervals, indexed by code (bits 4:3 period, 2:0 frequency)
    localparam int unsigned EXP [32] = '{
        1560, 2075, 2590, 3120, 1872, 2184, 2340, 2808,
         780, 1037, 1295, 1560,  936, 1092, 1170, 1404,
         390,  519,  647,  780,  468,  546,  585,  702,
         195,  259,  324,  390,  234,  273,  293,  351
    };

    always #2.5 clk = ~clk;

    ref_interval_timer uut (
        .clk             (clk),
        .rst             (rst),
        .cfg_code        (cfg_code),
        .cfg_load        (cfg_load),
        .ref_ack         (ref_ack),
        .ref_req         (ref_req),
        .ref_urgent      (ref_urgent),
        .pend_count      (pend_count),
        .interval_cycles (interval_cycles)
    );

    task automatic check(string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic load_code(logic [4:0] c);
        cfg_code = c;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_code = '0; cfg_load = 1'b0; ref_ack = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 interval in reset", interval_cycles, 1560);
        check("R1 pend in reset", pend_count, 0);
        check("R1 req in reset", ref_req, 0);
        check("R1 urgent in reset", ref_urgent, 0);

        // R4: first expiry lands on the 1560th edge after release
        rst = 1'b0;
        repeat (1559) @(negedge clk);
        check("R4 no req one edge early", ref_req, 0);
        @(negedge clk);
        check("R4 req at interval", ref_req, 1);
        check("R6 pend after first expiry", pend_count, 1);
        check("R8 not urgent at one", ref_urgent, 0);

        // R5: keeps counting while unacknowledged
        repeat (1559) @(negedge clk);
        check("R5 pend before second", pend_count, 1);
        @(negedge clk);
        check("R5 pend after second", pend_count, 2);
        check("R8 urgent at two", ref_urgent, 1);

        // R7: acknowledge drains, ignored at zero
        ref_ack = 1'b1;
        @(negedge clk);
        check("R7 ack to one", pend_count, 1);
        check("R8 urgent cleared", ref_urgent, 0);
        @(negedge clk);
        check("R7 ack to zero", pend_count, 0);
        check("R8 req cleared", ref_req, 0);
        @(negedge clk);
        check("R7 ack at zero ignored", pend_count, 0);
        ref_ack = 1'b0;

        // R2: walk all codes
        for (int c = 0; c < 32; c++) begin
            load_code(5'(c));
            check($sformatf("R2 interval code %0d", c), interval_cycles, EXP[c]);
        end
        check("R4 loads add no expiry", pend_count, 0);

        // R4: code without load is not stored
        cfg_code = 5'b00000;
        @(negedge clk);
        check("R4 code held without load", interval_cycles, 351);

        // R3: aliasing codes
        load_code(5'b00000);
        check("R3 code 00000", interval_cycles, 1560);
        load_code(5'b01011);
        check("R3 code 01011", interval_cycles, 1560);

        // R4/R5/R6 on the shortest interval (195)
        load_code(5'b11000);
        repeat (194) @(negedge clk);
        check("R4 no req before 195", ref_req, 0);
        @(negedge clk);
        check("R4 req at 195 after load", pend_count, 1);
        repeat (195) @(negedge clk);
        check("R5 second at 390", pend_count, 2);
        repeat (1560) @(negedge clk);
        check("R6 saturates at 8", pend_count, 8);

        ref_ack = 1'b1;
        repeat (3) @(negedge clk);
        ref_ack = 1'b0;
        check("R7 three acks", pend_count, 5);
        repeat (191) @(negedge clk);
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        check("R7 ack with expiry holds", pend_count, 5);
        check("R8 urgent at five", ref_urgent, 1);

        // R4: a load keeps owed refreshes
        load_code(5'b10011);
        check("R4 load keeps pending", pend_count, 5);
        check("R2 interval 3.9us 200MHz", interval_cycles, 780);

        // R1: reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 pend after reset", pend_count, 0);
        check("R1 interval after reset", interval_cycles, 1560);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule